// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache with Bus-Watch Invalidate

This block is a direct-mapped, write-through byte cache between a processor request port and a 32-bit main-memory port. A byte address is split into a tag, a line index and a byte offset. Each line holds one 4-byte block, its tag and a valid flag. A cacheable read that hits is answered in the request cycle. A cacheable read that misses fetches the whole block, writes it into the indexed line, and then returns the byte from the line on the following cycle. Writes always go to memory as a single byte-lane transfer. A write also refreshes the line when it hits, but a write miss never allocates a line.

A separate bus-watch input reports block addresses written by other bus masters. Any valid line that holds such a block is invalidated. If a bus-watch report and a line fill hit the same block in the same cycle, the line ends up invalid. A per-request noncacheable flag sends the access straight to memory. Such an access neither allocates a line nor updates one. The processor port uses a valid/ready handshake: the processor holds its request stable until ready, and it stalls for the whole miss.

The number of lines is set by the index width parameter. With a 24-bit address and a 14-bit index, the cache has 16K lines (64 KB of data).

Top module: `wt_snoop_cache`

## Requirements
- R1: Address fields are tag = addr[ADDR_W-1:IDX_W+2], index = addr[IDX_W+1:2], offset = addr[1:0]. Byte k of a block is bits [8k+7:8k] of the memory word. With ADDR_W=24 and IDX_W=14 this gives an 8-bit tag, a 14-bit index and a 2-bit offset.
- R2: A cacheable read whose indexed line is valid with an equal tag raises cpu_ready in the request cycle, with the cached byte on cpu_rdata and no memory request.
- R3: A cacheable read miss issues one memory read of word address addr[ADDR_W-1:2] and fills the line at the acknowledge. cpu_ready and the byte follow one cycle after mem_ack, and later reads of the block hit.
- R4: Two blocks with equal index and different tags evict each other, so alternating reads between them always miss.
- R5: Every write issues exactly one memory write to addr[ADDR_W-1:2]. mem_be has only bit addr[1:0] set, and the byte appears in that lane of mem_wdata.
- R6: A write hit updates the cached byte, so the next read hits with the new value. A write miss does not allocate, so the next read of that block misses.
- R7: A bus-watch report (snp_valid with block address snp_addr) whose block is held in a valid line invalidates it. A report for a different tag at the same index leaves the line valid.
- R8: A bus-watch report for the block being filled, in the same cycle as the fill, leaves the line invalid. The read in progress still returns the fetched byte.
- R9: A noncacheable read returns the byte from mem_rdata in the acknowledge cycle and allocates nothing. A noncacheable write goes to memory and leaves any cached copy unchanged.
- R10: After reset all lines are invalid, and cpu_ready and mem_req are low while no request is presented. cpu_ready is raised only while cpu_valid is high.
- R11: mem_req stays high with a stable address and direction until mem_ack. Writes and noncacheable reads complete in the mem_ack cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_nc | input | 1 | Noncacheable access |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid with cpu_ready on reads |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_be | output | 4 | Byte-lane enables (all set on reads) |
| mem_wdata | output | 32 | Write word, byte replicated in all lanes |
| mem_rdata | input | 32 | Read word |
| mem_ack | input | 1 | Memory completes the transfer |
| snp_valid | input | 1 | Another master wrote a block this cycle |
| snp_addr | input | ADDR_W-2 | Block address of that write |

## Verification
The bench builds the cache with ADDR_W=8 and IDX_W=3. This gives a 256-byte space with 8 lines and 3-bit tags, so every byte address can be read in one sweep. The same sweep also reaches every tag that aliases onto each line. The expected data, hit or miss, cycle count and memory traffic come from a shadow tag/data model in the bench, which tracks fills, write hits and invalidations. The small index also makes it cheap to place a bus-watch report exactly on a fill cycle.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_RESP} ctl_state_e;

  function automatic logic [7:0] pick_byte(input logic [31:0] w, input logic [1:0] off);
    return w[{off, 3'b000} +: 8];
  endfunction

  function automatic logic [31:0] merge_byte(input logic [31:0] w, input logic [1:0] off,
                                             input logic [7:0] b);
    logic [31:0] r;
    r = w;
    r[{off, 3'b000} +: 8] = b;
    return r;
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] off);
    return 4'b0001 << off;
  endfunction

endpackage

// File: rtl/dmc_line_store.sv
module dmc_line_store
  import dmc_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int TAG_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [31:0]      rd_word,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [31:0]      fill_word,
  input  logic             upd_en,
  input  logic [1:0]       upd_off,
  input  logic [7:0]       upd_byte,
  input  logic             snp_en,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic [TAG_W-1:0] snp_tag,
  output logic             snp_kill
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [LINES];
  logic [31:0]      dat_q [LINES];
  logic             fill_same;

  assign rd_valid = vld_q[idx];
  assign rd_tag   = tag_q[idx];
  assign rd_word  = dat_q[idx];

  // A report that lands on a line being filled is compared with the incoming tag.
  assign fill_same = fill_en && (idx == snp_idx);
  assign snp_kill  = snp_en && (fill_same ? (fill_tag == snp_tag)
                                          : (vld_q[snp_idx] && tag_q[snp_idx] == snp_tag));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (fill_en)  vld_q[idx]     <= 1'b1;
      if (snp_kill) vld_q[snp_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[idx] <= fill_tag;
      dat_q[idx] <= fill_word;
    end else if (upd_en) begin
      dat_q[idx] <= merge_byte(dat_q[idx], upd_off, upd_byte);
    end
  end

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_valid,
  input  logic cpu_we,
  input  logic cpu_nc,
  input  logic hit,
  input  logic mem_ack,
  output logic cpu_ready,
  output logic mem_req,
  output logic fill_en,
  output logic upd_en,
  output logic rd_from_mem,
  output logic in_idle
);
  ctl_state_e st_q, st_d;

  always_comb begin
    st_d        = st_q;
    cpu_ready   = 1'b0;
    mem_req     = 1'b0;
    fill_en     = 1'b0;
    upd_en      = 1'b0;
    rd_from_mem = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cpu_valid) begin
          if (!cpu_we && !cpu_nc && hit) cpu_ready = 1'b1;
          else                           st_d = ST_BUS;
        end
      end
      ST_BUS: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          if (cpu_we) begin
            cpu_ready = 1'b1;
            upd_en    = !cpu_nc && hit;
            st_d      = ST_IDLE;
          end else if (cpu_nc) begin
            cpu_ready   = 1'b1;
            rd_from_mem = 1'b1;
            st_d        = ST_IDLE;
          end else begin
            fill_en = 1'b1;
            st_d    = ST_RESP;
          end
        end
      end
      ST_RESP: begin
        cpu_ready = 1'b1;
        st_d      = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign in_idle = (st_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_we,
  input  logic              cpu_nc,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  input  logic              snp_valid,
  input  logic [ADDR_W-3:0] snp_addr
);
  localparam int TAG_W = ADDR_W - IDX_W - 2;
  localparam int BLK_W = ADDR_W - 2;

  logic [TAG_W-1:0] req_tag, snp_tag, rd_tag;
  logic [IDX_W-1:0] req_idx, snp_idx;
  logic [1:0]       req_off;
  logic             rd_valid;
  logic [31:0]      rd_word;

  // Named internal events, observed by the bound checker.
  logic lookup_hit, fill_en, upd_en, snp_kill, in_idle, rd_from_mem;

  assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign req_idx = cpu_addr[IDX_W+1:2];
  assign req_off = cpu_addr[1:0];
  assign snp_tag = snp_addr[BLK_W-1 -: TAG_W];
  assign snp_idx = snp_addr[IDX_W-1:0];

  assign lookup_hit = rd_valid && (rd_tag == req_tag);

  dmc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx      (req_idx),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag),
    .rd_word  (rd_word),
    .fill_en  (fill_en),
    .fill_tag (req_tag),
    .fill_word(mem_rdata),
    .upd_en   (upd_en),
    .upd_off  (req_off),
    .upd_byte (cpu_wdata),
    .snp_en   (snp_valid),
    .snp_idx  (snp_idx),
    .snp_tag  (snp_tag),
    .snp_kill (snp_kill)
  );

  dmc_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_valid  (cpu_valid),
    .cpu_we     (cpu_we),
    .cpu_nc     (cpu_nc),
    .hit        (lookup_hit),
    .mem_ack    (mem_ack),
    .cpu_ready  (cpu_ready),
    .mem_req    (mem_req),
    .fill_en    (fill_en),
    .upd_en     (upd_en),
    .rd_from_mem(rd_from_mem),
    .in_idle    (in_idle)
  );

  assign mem_we    = mem_req && cpu_we;
  assign mem_addr  = cpu_addr[ADDR_W-1:2];
  assign mem_be    = cpu_we ? lane_mask(req_off) : 4'hF;
  assign mem_wdata = {4{cpu_wdata}};
  assign cpu_rdata = rd_from_mem ? pick_byte(mem_rdata, req_off) : pick_byte(rd_word, req_off);

endmodule

// File: rtl/wt_snoop_cache_chk.sv
module wt_snoop_cache_chk #(
  parameter int BLK_W = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_valid,
  input logic             cpu_ready,
  input logic             cpu_we,
  input logic             cpu_nc,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack,
  input logic [BLK_W-1:0] mem_addr,
  input logic [3:0]       mem_be,
  input logic             lookup_hit,
  input logic             in_idle,
  input logic             fill_en,
  input logic             upd_en
);

  a_r10_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_valid);

  a_r2_hit_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && cpu_valid && !cpu_we && !cpu_nc && lookup_hit) |-> (cpu_ready && !mem_req));

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r5_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ($countones(mem_be) == 1));

  a_r3_fill_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (cpu_ready && !mem_req));

  a_r9_nc_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_nc) |-> (!fill_en && !upd_en));

  a_r6_wr_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_we) |-> !fill_en);

endmodule

bind wt_snoop_cache wt_snoop_cache_chk #(.BLK_W(BLK_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_valid (cpu_valid),
  .cpu_ready (cpu_ready),
  .cpu_we    (cpu_we),
  .cpu_nc    (cpu_nc),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be),
  .lookup_hit(lookup_hit),
  .in_idle   (in_idle),
  .fill_en   (fill_en),
  .upd_en    (upd_en)
);

// File: tb/wt_snoop_cache_test.sv
module wt_snoop_cache_test;
  localparam int AW = 8;
  localparam int IW = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0, cpu_we = 1'b0, cpu_nc = 1'b0;
  logic [7:0]  cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready;
  logic [7:0]  cpu_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [5:0]  mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata;
  logic        snp_valid = 1'b0;
  logic [5:0]  snp_addr = '0;

  logic        xw_en = 1'b0;
  logic [7:0]  xw_addr = '0, xw_data = '0;

  logic [7:0]  mem  [256];
  logic [7:0]  gold [256];
  logic        sh_v [8];
  logic [2:0]  sh_t [8];
  logic [31:0] sh_d [8];
  logic [3:0]  last_be;
  int          n_acc;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  wt_snoop_cache #(.ADDR_W(AW), .IDX_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_we(cpu_we), .cpu_nc(cpu_nc), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .snp_valid(snp_valid), .snp_addr(snp_addr)
  );

  function automatic logic [7:0] init_byte(input int a);
    return 8'(a * 37 + 11);
  endfunction

  // Memory model: acknowledges one cycle after a request appears.
  assign mem_rdata = {mem[{mem_addr, 2'd3}], mem[{mem_addr, 2'd2}],
                      mem[{mem_addr, 2'd1}], mem[{mem_addr, 2'd0}]};

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      n_acc   <= 0;
      last_be <= '0;
      for (int a = 0; a < 256; a++) mem[a] <= init_byte(a);
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && mem_ack) begin
        n_acc <= n_acc + 1;
        if (mem_we) begin
          last_be <= mem_be;
          for (int l = 0; l < 4; l++)
            if (mem_be[l]) mem[{mem_addr, 2'(l)}] <= mem_wdata[8*l +: 8];
        end
      end
      if (xw_en) mem[xw_addr] <= xw_data;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_op(input logic we, input logic nc, input logic [7:0] a,
                        input logic [7:0] wd, output logic [7:0] rd, output int cyc);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_nc = nc; cpu_addr = a; cpu_wdata = wd;
    cyc = 0;
    #1;
    while (!cpu_ready) begin
      @(negedge clk);
      #1;
      cyc++;
    end
    rd = cpu_rdata;
    @(posedge clk);
    #1;
    cpu_valid = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, input logic nc, input string lbl);
    logic [2:0] idx, tg;
    logic [1:0] off;
    logic       hit;
    logic [7:0] exp, got;
    int         cyc, n0;
    string      req;
    idx = a[4:2]; tg = a[7:5]; off = a[1:0];
    hit = !nc && sh_v[idx] && (sh_t[idx] == tg);
    exp = hit ? sh_d[idx][8*off +: 8] : gold[a];
    req = nc ? "R9" : (hit ? "R2" : "R3");
    n0 = n_acc;
    cpu_op(1'b0, nc, a, 8'h00, got, cyc);
    chk(got === exp, {req, " data ", lbl}, int'(got), int'(exp));
    chk((n_acc - n0) == (hit ? 0 : 1), {req, " memory reads ", lbl}, n_acc - n0, hit ? 0 : 1);
    chk(cyc == (hit ? 0 : (nc ? 2 : 3)), {"R11 read latency ", lbl}, cyc, hit ? 0 : (nc ? 2 : 3));
    if (!nc && !hit) begin
      sh_v[idx] = 1'b1;
      sh_t[idx] = tg;
      sh_d[idx] = {gold[{a[7:2], 2'd3}], gold[{a[7:2], 2'd2}],
                   gold[{a[7:2], 2'd1}], gold[{a[7:2], 2'd0}]};
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] v, input logic nc,
                          input string lbl);
    logic [2:0] idx;
    logic       hit;
    logic [7:0] got;
    int         cyc, n0;
    idx = a[4:2];
    hit = !nc && sh_v[idx] && (sh_t[idx] == a[7:5]);
    n0 = n_acc;
    cpu_op(1'b1, nc, a, v, got, cyc);
    gold[a] = v;
    chk((n_acc - n0) == 1, {"R5 one write ", lbl}, n_acc - n0, 1);
    chk(last_be == (4'b0001 << a[1:0]), {"R5 lane ", lbl}, int'(last_be), int'(4'b0001 << a[1:0]));
    for (int k = 0; k < 4; k++)
      chk(mem[{a[7:2], 2'(k)}] == gold[{a[7:2], 2'(k)}], {"R5 memory byte ", lbl},
          int'(mem[{a[7:2], 2'(k)}]), int'(gold[{a[7:2], 2'(k)}]));
    chk(cyc == 2, {"R11 write latency ", lbl}, cyc, 2);
    if (hit) sh_d[idx][8*a[1:0] +: 8] = v;
  endtask

  task automatic snoop(input logic [7:0] a, input logic wr, input logic [7:0] v);
    @(negedge clk);
    snp_valid = 1'b1; snp_addr = a[7:2];
    xw_en = wr; xw_addr = a; xw_data = v;
    @(posedge clk);
    #1;
    snp_valid = 1'b0; xw_en = 1'b0;
    if (wr) gold[a] = v;
    if (sh_v[a[4:2]] && sh_t[a[4:2]] == a[7:5]) sh_v[a[4:2]] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R10 actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) gold[a] = init_byte(a);
    for (int i = 0; i < 8; i++) begin sh_v[i] = 1'b0; sh_t[i] = '0; sh_d[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_ready == 1'b0, "R10 ready after reset", int'(cpu_ready), 0);
    chk(mem_req == 1'b0, "R10 mem_req after reset", int'(mem_req), 0);

    // R1/R2/R3: every byte address, ascending then descending.
    for (int a = 0; a < 256; a++) do_read(8'(a), 1'b0, "R1 sweep up");
    for (int a = 255; a >= 0; a--) do_read(8'(a), 1'b0, "R1 sweep down");

    // R4: aliasing blocks on line 2.
    do_read(8'h08, 1'b0, "R4 alias a");
    do_read(8'hE8, 1'b0, "R4 alias b");
    do_read(8'h09, 1'b0, "R4 alias a again");
    do_read(8'hEA, 1'b0, "R4 alias b again");

    // R5/R6: write hit updates the line, write miss does not allocate.
    do_read(8'hE8, 1'b0, "R6 prefetch");
    do_write(8'hE9, 8'h5A, 1'b0, "R6 write hit");
    do_read(8'hE9, 1'b0, "R6 read after write hit");
    do_write(8'h0A, 8'h33, 1'b0, "R6 write miss");
    do_read(8'h0A, 1'b0, "R6 read after write miss");
    for (int a = 0; a < 32; a++) do_write(8'(a), 8'(a) ^ 8'hC3, 1'b0, "R5 write sweep");
    for (int a = 0; a < 32; a++) do_read(8'(a), 1'b0, "R5 readback");

    // R7: bus-watch invalidate, matching and non-matching tag.
    do_read(8'h40, 1'b0, "R7 fill");
    snoop(8'h41, 1'b1, 8'hA5);
    do_read(8'h41, 1'b0, "R7 after matching report");
    do_read(8'h44, 1'b0, "R7 fill other");
    snoop(8'h64, 1'b0, 8'h00);
    do_read(8'h45, 1'b0, "R7 after other-tag report");

    // R8: report for the block landing in the fill cycle.
    fork
      do_read(8'h88, 1'b0, "R8 fill with report");
      begin
        do @(negedge clk); while (!mem_ack);
        snp_valid = 1'b1; snp_addr = 6'h22;
        @(posedge clk);
        #1 snp_valid = 1'b0;
      end
    join
    sh_v[2] = 1'b0;
    do_read(8'h89, 1'b0, "R8 line left invalid");

    // R9: noncacheable read and write.
    do_read(8'h90, 1'b1, "R9 nc read");
    do_read(8'h90, 1'b0, "R9 no allocation");
    do_write(8'h91, 8'h77, 1'b1, "R9 nc write");
    do_read(8'h91, 1'b0, "R9 cached copy kept");
    do_read(8'h91, 1'b1, "R9 nc read sees memory");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule